// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

A single timer channel behind a small synchronous register bus. Software writes a start value, picks a counting mode, a prescale ratio and a counter width, then enables counting. On every prescaled tick the counter steps down by one. What happens when it reaches zero depends on the mode. It can wrap through its full range, reload the programmed start value, or stop at zero. Reaching zero latches a raw interrupt flag. The flag drives the interrupt pin only while the interrupt enable bit is set, and software clears it with a write to a dedicated address.

The counter runs downward. Software that wants a rising count subtracts the value it reads from all-ones. Reads return data on the clock edge that follows the request. Any control update, such as setting the run bit while keeping the prescale field, is a read-modify-write of the control word.

Top module: `pdt_timer`

## Requirements
- R1: After reset the control word reads 0x20, the count register reads 0x0000FFFF (all-ones in the reset 16-bit width), the status read at 0x0C is 0 and `irq_o` is low.
- R2: The byte address selects the register: 0x00 is the start value (read/write), 0x04 is the count (read-only, writes ignored), 0x08 is control, and 0x0C reads the raw flag in bit 0. Control bit 4 and bits above 7 read as zero. An access whose two low address bits are not zero is ignored. Read data appears one cycle after the request and is zero when no read is made.
- R3: The counter decrements once per prescaled tick while control bit 7 is set, and holds its value while bit 7 is clear.
- R4: Control bits 3:2 set the prescale: 00 gives one tick per clock, 01 one tick per 16 clocks, 10 one tick per 256 clocks, and 11 behaves as 10. The first tick comes on the Nth clock after counting is enabled or the start value is written.
- R5: A write to 0x00 loads the counter in that same cycle and restarts the prescaler. It takes priority over a tick in the same cycle.
- R6: With control bits 6 and 0 both clear, a tick at zero wraps the counter to all-ones of the selected width.
- R7: With bit 6 set and bit 0 clear, a tick at zero reloads the counter from the start-value register.
- R8: With bit 0 set (overriding bit 6), the counter stops at zero and stays there until the start value is written again.
- R9: Control bit 1 set selects a 32-bit counter. When it is clear, only the low 16 bits count and the upper 16 bits of the count read as zero.
- R10: A tick that leaves the counter at zero sets the raw flag, except a one-shot tick that holds at zero. The flag stays set until a write to 0x0C clears it. A new zero event in the same cycle wins over the clear.
- R11: `irq_o` is high exactly when the raw flag is set and control bit 5 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read request |
| irq_o | output | 1 | Interrupt, raw flag gated by enable |

## Verification
The bench uses the default parameters: a 32-bit data path with prescale shifts of 4 and 8. At this size the divide-by-16 and divide-by-256 boundaries can be checked one clock on either side. Small start values keep the zero crossing, the 16-bit and 32-bit wraps and the periodic reload within a few cycles. The bench also checks that a rewrite of the start value restarts the prescaler, by measuring the tick position against the rewrite rather than against the enable.

// File: rtl/pdt_pkg.sv
// Package pdt_pkg
// Shared constants and types for the prescaled down-counting timer.
// Assumes a 32-bit bus with word-aligned registers.
package pdt_pkg;
    localparam int CB_EN   = 7;
    localparam int CB_PER  = 6;
    localparam int CB_IE   = 5;
    localparam int CB_PS   = 2;
    localparam int CB_W32  = 1;
    localparam int CB_ONE  = 0;
    localparam logic [7:0] CTRL_RESET = 8'h20;

    typedef enum logic [1:0] {
        SEL_LOAD  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_CLEAR = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        RUN_FREE     = 2'd0,
        RUN_PERIODIC = 2'd1,
        RUN_ONESHOT  = 2'd2
    } run_mode_e;
endpackage

// File: rtl/pdt_prescale.sv
// Module pdt_prescale
// Divides the clock into count ticks by 1, 2**SH_MID or 2**SH_HI.
// Assumes SH_MID < SH_HI. The divider sits at zero while disabled or on restart.
module pdt_prescale #(
    parameter int SH_MID = 4,
    parameter int SH_HI  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       restart,
    input  logic [1:0] ps,
    output logic       tick
);
    localparam int PRE_W = SH_HI;
    localparam logic [PRE_W-1:0] LIM_MID = PRE_W'((1 << SH_MID) - 1);
    localparam logic [PRE_W-1:0] LIM_HI  = PRE_W'((1 << SH_HI) - 1);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;

    // Pick the terminal divider count for the selected ratio (code 3 acts as code 2).
    always_comb begin
        case (ps)
            2'd0:    limit = '0;
            2'd1:    limit = LIM_MID;
            default: limit = LIM_HI;
        endcase
    end

    assign tick = en && (pre_q >= limit);

    // Advance the divider, returning to zero on tick, restart or disable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_q <= '0;
        else if (restart || !en || tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/pdt_counter.sv
// Module pdt_counter
// The down counter with free-wrap, periodic-reload and one-shot behaviour at zero.
// Assumes CNT_W is even. In narrow mode only the low half counts.
module pdt_counter
    import pdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             wide,
    input  run_mode_e        mode,
    output logic [CNT_W-1:0] count_vis,
    output logic             zero_evt
);
    localparam int HALF_W = CNT_W / 2;
    localparam logic [CNT_W-1:0] LOW_MASK = {{(CNT_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] step;
    logic             at_zero;
    logic             holding;

    assign count_vis = wide ? cnt_q : (cnt_q & LOW_MASK);
    assign at_zero   = (count_vis == '0);
    assign holding   = at_zero && (mode == RUN_ONESHOT);

    // Compute the value one tick later for the current mode and width.
    always_comb begin
        if (!at_zero)
            step = count_vis - 1'b1;
        else if (mode == RUN_ONESHOT)
            step = count_vis;
        else if (mode == RUN_PERIODIC)
            step = reload_val;
        else
            step = '1;
        if (!wide)
            step = step & LOW_MASK;
    end

    // Choose between a bus load, a tick step and holding.
    always_comb begin
        if (load_wr)
            cnt_nxt = load_val;
        else if (tick)
            cnt_nxt = step;
        else
            cnt_nxt = cnt_q;
    end

    assign zero_evt = tick && !load_wr && !holding && (step == '0);

    // Counter register, all-ones out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '1;
        else
            cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/pdt_regs.sv
// Module pdt_regs
// Register bus decode, control fields, start value, raw flag and registered read data.
// Assumes word-aligned accesses. Other accesses are ignored.
module pdt_regs
    import pdt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] count_vis,
    input  logic              zero_evt,
    output logic [DATA_W-1:0] load_q,
    output logic              load_wr,
    output logic              raw_q,
    output logic              c_en,
    output logic              c_per,
    output logic              c_ie,
    output logic [1:0]        c_ps,
    output logic              c_w32,
    output logic              c_one
);
    reg_sel_e   sel;
    logic       hit;
    logic       wr_acc;
    logic       rd_acc;
    logic       ctrl_wr;
    logic       clr_wr;
    logic [7:0] ctrl_vis;

    assign sel     = reg_sel_e'(bus_addr[3:2]);
    assign hit     = bus_sel && (bus_addr[1:0] == 2'b00);
    assign wr_acc  = hit && bus_wr;
    assign rd_acc  = hit && !bus_wr;
    assign load_wr = wr_acc && (sel == SEL_LOAD);
    assign ctrl_wr = wr_acc && (sel == SEL_CTRL);
    assign clr_wr  = wr_acc && (sel == SEL_CLEAR);
    assign ctrl_vis = {c_en, c_per, c_ie, 1'b0, c_ps, c_w32, c_one};

    // Control fields: updated by a control write, reset to CTRL_RESET.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_en  <= CTRL_RESET[CB_EN];
            c_per <= CTRL_RESET[CB_PER];
            c_ie  <= CTRL_RESET[CB_IE];
            c_ps  <= CTRL_RESET[CB_PS+1:CB_PS];
            c_w32 <= CTRL_RESET[CB_W32];
            c_one <= CTRL_RESET[CB_ONE];
        end else if (ctrl_wr) begin
            c_en  <= bus_wdata[CB_EN];
            c_per <= bus_wdata[CB_PER];
            c_ie  <= bus_wdata[CB_IE];
            c_ps  <= bus_wdata[CB_PS+1:CB_PS];
            c_w32 <= bus_wdata[CB_W32];
            c_one <= bus_wdata[CB_ONE];
        end
    end

    // Start-value register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            load_q <= '0;
        else if (load_wr)
            load_q <= bus_wdata;
    end

    // Raw flag: a zero event sets it and wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            raw_q <= 1'b0;
        else if (zero_evt)
            raw_q <= 1'b1;
        else if (clr_wr)
            raw_q <= 1'b0;
    end

    // Registered read data, zero when no read is made.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (rd_acc) begin
            case (sel)
                SEL_LOAD:  bus_rdata <= load_q;
                SEL_COUNT: bus_rdata <= count_vis;
                SEL_CTRL:  bus_rdata <= DATA_W'(ctrl_vis);
                default:   bus_rdata <= DATA_W'(raw_q);
            endcase
        end else
            bus_rdata <= '0;
    end
endmodule

// File: rtl/pdt_timer.sv
// Module pdt_timer
// Top of the prescaled down-counting timer: register bank, prescaler and counter.
// Assumes a single clock domain. The interrupt is level, raw flag gated by enable.
module pdt_timer
    import pdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SH_MID = 4,
    parameter int SH_HI  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    localparam int CNT_W = DATA_W;

    logic [CNT_W-1:0] count_vis;
    logic [CNT_W-1:0] load_q;
    logic             load_wr;
    logic             zero_evt;
    logic             raw_q;
    logic             tick;
    logic             c_en, c_per, c_ie, c_w32, c_one;
    logic [1:0]       c_ps;
    run_mode_e        mode;

    // Mode decode: one-shot overrides periodic.
    always_comb begin
        if (c_one)
            mode = RUN_ONESHOT;
        else if (c_per)
            mode = RUN_PERIODIC;
        else
            mode = RUN_FREE;
    end

    assign irq_o = raw_q && c_ie;

    pdt_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count_vis(count_vis), .zero_evt(zero_evt),
        .load_q(load_q), .load_wr(load_wr), .raw_q(raw_q),
        .c_en(c_en), .c_per(c_per), .c_ie(c_ie), .c_ps(c_ps),
        .c_w32(c_w32), .c_one(c_one)
    );

    pdt_prescale #(.SH_MID(SH_MID), .SH_HI(SH_HI)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(c_en), .restart(load_wr),
        .ps(c_ps), .tick(tick)
    );

    pdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load_wr(load_wr),
        .load_val(bus_wdata), .reload_val(load_q), .wide(c_w32),
        .mode(mode), .count_vis(count_vis), .zero_evt(zero_evt)
    );
endmodule

// File: rtl/pdt_timer_chk.sv
// Module pdt_timer_chk
// Property checks on the timer, attached to pdt_timer by the bind below.
// Assumes the same clock and synchronous reset as the timer.
module pdt_timer_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [3:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_o,
    input logic [DATA_W-1:0] count_vis,
    input logic              load_wr,
    input logic              zero_evt,
    input logic              raw_q,
    input logic              c_en,
    input logic              c_ie,
    input logic              c_w32,
    input logic              c_one
);
    localparam int HALF_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] LOW_MASK = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

    logic any_wr;
    logic clr_wr;
    logic cnt_rd;
    assign any_wr = bus_sel && bus_wr;
    assign clr_wr = any_wr && (bus_addr == 4'hC);
    assign cnt_rd = bus_sel && !bus_wr && (bus_addr == 4'h4);

    assert_rdata_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> bus_rdata == '0);

    assert_hold_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_en && !any_wr) |=> $stable(count_vis));

    assert_load_now_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> count_vis == (c_w32 ? $past(bus_wdata) : ($past(bus_wdata) & LOW_MASK)));

    assert_oneshot_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_one && count_vis == '0 && !any_wr) |=> count_vis == '0);

    assert_narrow_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_rd && !c_w32) |=> (bus_rdata & ~LOW_MASK) == '0);

    assert_evt_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |=> raw_q);

    assert_raw_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_q && !clr_wr) |=> raw_q);

    assert_raw_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !zero_evt) |=> !raw_q);

    assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (raw_q && c_ie));
endmodule

bind pdt_timer pdt_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .count_vis(count_vis), .load_wr(load_wr),
    .zero_evt(zero_evt), .raw_q(raw_q), .c_en(c_en), .c_ie(c_ie),
    .c_w32(c_w32), .c_one(c_one)
);

// File: tb/tb_pdt_timer.sv
// Directed bench for pdt_timer. Tasks are entered and left on a falling edge.
module tb_pdt_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    pdt_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Stop, clear, load, then enable with the given control word.
    task automatic prep(input logic [31:0] ld, input logic [31:0] ctl);
        wr(4'h8, 32'h0);
        wr(4'hC, 32'h0);
        wr(4'h0, ld);
        wr(4'h8, ctl);
    endtask

    task automatic count_after(input string tag, input logic [31:0] ld, input logic [31:0] ctl,
                               input int n, input logic [31:0] exp);
        logic [31:0] v;
        prep(ld, ctl);
        idle(n);
        rd(4'h4, v);
        check(tag, v, exp);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(4'h8, v); check("R1 ctrl", v, 32'h20);
        rd(4'h4, v); check("R1 count", v, 32'h0000FFFF);
        rd(4'hC, v); check("R1 status", v, 32'h0);
        check("R1 irq", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(4'h8, 32'hFFFF_FFFF);
        rd(4'h8, v); check("R2 ctrl mask", v, 32'hEF);
        wr(4'h8, 32'h0);
        wr(4'h0, 32'h1234_5678);
        rd(4'h0, v); check("R2 load rb", v, 32'h1234_5678);
        wr(4'h4, 32'h55);
        rd(4'h4, v); check("R2 count ro / R9 narrow", v, 32'h5678);
        wr(4'h1, 32'h99);
        rd(4'h0, v); check("R2 misaligned ignored", v, 32'h1234_5678);
        wr(4'h8, 32'h02);
        rd(4'h4, v); check("R9 wide read", v, 32'h1234_5678);
    endtask

    task automatic t_free();
        count_after("R3 decrement", 5, 32'h82, 3, 2);
        count_after("R3 hold disabled", 5, 32'h02, 10, 5);
        count_after("R6 reach zero", 2, 32'h82, 2, 0);
        count_after("R6 wrap32", 2, 32'h82, 3, 32'hFFFF_FFFF);
        count_after("R6 wrap16", 1, 32'h80, 2, 32'h0000_FFFF);
        count_after("R9 low half counts", 32'h12345, 32'h80, 1, 32'h2344);
    endtask

    task automatic t_periodic();
        count_after("R7 zero", 3, 32'hC2, 3, 0);
        count_after("R7 reload", 3, 32'hC2, 4, 3);
        count_after("R7 after reload", 3, 32'hC2, 5, 2);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        count_after("R8 stop", 2, 32'h83, 10, 0);
        count_after("R8 overrides periodic", 2, 32'hC3, 10, 0);
        wr(4'h0, 32'h4);
        rd(4'h4, v); check("R8 restart by load", v, 32'h4);
    endtask

    task automatic t_prescale();
        count_after("R4 div16 before", 10, 32'h86, 15, 10);
        count_after("R4 div16 tick", 10, 32'h86, 16, 9);
        count_after("R4 div256 before", 10, 32'h8A, 255, 10);
        count_after("R4 div256 tick", 10, 32'h8A, 256, 9);
        count_after("R4 code3 before", 10, 32'h8E, 255, 10);
        count_after("R4 code3 tick", 10, 32'h8E, 256, 9);
    endtask

    task automatic t_restart();
        logic [31:0] v;
        prep(50, 32'h86); idle(10);
        wr(4'h0, 20); idle(15);
        rd(4'h4, v); check("R5 restart before", v, 20);
        prep(50, 32'h86); idle(10);
        wr(4'h0, 20); idle(16);
        rd(4'h4, v); check("R5 restart tick", v, 19);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        prep(2, 32'hA2); idle(1);
        check("R11 irq before zero", {31'b0, irq_o}, 0);
        rd(4'hC, v); check("R10 status before zero", v, 0);
        check("R11 irq at zero", {31'b0, irq_o}, 1);
        rd(4'hC, v); check("R10 status set", v, 1);
        idle(8);
        check("R10 sticky irq", {31'b0, irq_o}, 1);
        wr(4'hC, 32'h0);
        check("R11 irq after clear", {31'b0, irq_o}, 0);
        rd(4'hC, v); check("R10 status cleared", v, 0);
        prep(2, 32'h82); idle(5);
        check("R11 irq masked", {31'b0, irq_o}, 0);
        rd(4'hC, v); check("R10 status raw w/o enable", v, 1);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_free();
        t_periodic();
        t_oneshot();
        t_prescale();
        t_restart();
        t_irq();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule